// File: doc/BRIEF.md
# HDLC Receive Word Buffer with Frame Tags

This block sits between an HDLC deframer and a host bus. The deframer hands it one received byte per strobe, and it flags the final byte of each frame with that frame's CRC-error and non-octet status. The block gathers the bytes into 32-bit words, first byte in the lowest lane, and keeps up to eight such words in a FIFO. The word that closes a frame carries a count of its valid bytes and a set of frame tags. The host pulls the words out one at a time and sees the data and the tags of each word one cycle after its read strobe.

A level output tells the host when there is something worth reading. A mode input sets that output to trip at one stored word or at four. The frame being received can be thrown away with its stored words and its partly packed bytes, and any frame that has already ended stays in place. This happens on an abort that arrives inside a frame, or when the carrier-loss input is high while automatic carrier handling is enabled. When the buffer fills up, the frame in progress is cut short, and its pending word is marked as overrun. A soft clear input or the synchronous reset empties everything.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: Bytes of a frame are packed into a word in arrival order: the first byte goes in bits 7:0, the second in 15:8, the third in 23:16 and the fourth in 31:24. A full word of a frame that has not ended reads back with byte count 4 and all four tags at 0. Words read back in the order they were written.
- R2: A byte strobed with `in_last` closes its word at once, with 1 to 4 valid bytes. Lanes above the count read as zero. The word has `rd_last`=1, and `rd_crc` and `rd_nonoct` take the values of `in_crc_err` and `in_non_octet` from that byte.
- R3: At most eight words are stored. If a byte arrives while eight words are stored and a full word is waiting in the packing stage, the waiting word is given `rd_last`=1 and `rd_ovr`=1. That byte and the rest of the frame, up to and including its `in_last` byte, are discarded.
- R4: With `mode_4w`=0, `data_avail` is 1 when at least one word is stored. With `mode_4w`=1, it needs at least four stored words.
- R5: An `abort_in` pulse while a frame is being received removes all of that frame's stored words and packed bytes. Words of frames that ended earlier are kept.
- R6: While `carrier_lost`=1 and `auto_en`=1, the frame in progress is removed as in R5 and incoming bytes are ignored. With `auto_en`=0, `carrier_lost` has no effect.
- R7: An `abort_in` pulse when no frame is in progress leaves the stored words unchanged.
- R8: One cycle after `soft_clr`=1, or after reset, the buffer holds no words and the read outputs are zero.
- R9: `rd_en` on a cycle with no stored word makes all read outputs zero on the next cycle and consumes nothing. A later word is still returned in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_clr | input | 1 | Empties the buffer and the packing stage |
| in_valid | input | 1 | Received byte strobe |
| in_byte | input | 8 | Received byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_crc_err | input | 1 | CRC status of the frame, read with the last byte |
| in_non_octet | input | 1 | Non-octet status of the frame, read with the last byte |
| abort_in | input | 1 | Abort pulse from the deframer |
| carrier_lost | input | 1 | Carrier-loss level |
| auto_en | input | 1 | Enables carrier-loss handling |
| mode_4w | input | 1 | Threshold select: 0 for one word, 1 for four words |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 32 | Word returned by the last read |
| rd_nbytes | output | 3 | Valid byte count of that word (0 after an empty read) |
| rd_last | output | 1 | Word closes a frame |
| rd_ovr | output | 1 | Frame overran |
| rd_crc | output | 1 | Frame had a CRC error |
| rd_nonoct | output | 1 | Frame was not octet aligned |
| data_avail | output | 1 | Threshold reached |

## Verification
The embedded properties assume three things about the inputs. The status inputs `in_last`, `in_crc_err` and `in_non_octet` matter only on cycles with `in_valid`. `abort_in` comes as a pulse. `rst_n` is held low long enough for one clock edge. The empty-read property also assumes `mode_4w` stays at 0 between a read strobe and the check of its result. The stimulus meets all of this: it drives inputs only on falling edges, never sends an abort and a byte in the same cycle, and changes `mode_4w` only while no read is pending. Each directed scenario holds one condition at a time (full buffer, abort, carrier loss, clear) so that the expected words follow from the requirements alone.

// File: rtl/hdlc_rxf_pkg.sv
// Shared constants and the stored-word layout for the HDLC receive buffer.
// Assumes byte-wide input and a word of four bytes.
package hdlc_rxf_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int CNT_W      = $clog2(WORD_BYTES + 1);

    // One FIFO entry: frame tags, valid byte count, packed data
    typedef struct packed {
        logic              last;
        logic              ovr;
        logic              crc;
        logic              nonoct;
        logic [CNT_W-1:0]  nbytes;
        logic [WORD_W-1:0] data;
    } rxf_word_t;
endpackage

// File: rtl/hdlc_rxf_packer.sv
// Packing stage: assembles received bytes into one word, closes the word
// early at a frame end, detects overrun against a full store, and drops the
// rest of an overrun frame. A word stays here until the store accepts it.
// Assumes flush is asserted only while busy is high.
module hdlc_rxf_packer
    import hdlc_rxf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      soft_clr,
    input  logic      byte_ok,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic      byte_last,
    input  logic      byte_crc,
    input  logic      byte_non,
    input  logic      flush,
    input  logic      sink_ready,
    output logic      out_valid,
    output rxf_word_t out_word,
    output logic      busy
);
    rxf_word_t pk_q, pk_d;
    logic closed_q, closed_d;
    logic in_frame_q, in_frame_d;
    logic drop_q, drop_d;
    logic full_word, ready, take;

    // Word waiting to leave: four bytes gathered or frame closed
    always_comb begin
        full_word = (pk_q.nbytes == CNT_W'(WORD_BYTES));
        ready     = full_word | closed_q;
        out_valid = ready & ~(flush & ~closed_q);
        take      = out_valid & sink_ready;
    end

    assign out_word = pk_q;
    assign busy     = in_frame_q | drop_q;

    // Next state of the packing stage for this cycle's events
    always_comb begin
        int lane;
        pk_d       = pk_q;
        closed_d   = closed_q;
        in_frame_d = in_frame_q;
        drop_d     = drop_q;
        lane       = 0;
        if (take) begin
            pk_d     = '0;
            closed_d = 1'b0;
        end
        if (flush) begin
            if (!closed_q) begin
                pk_d     = '0;
                closed_d = 1'b0;
            end
            in_frame_d = 1'b0;
            drop_d     = 1'b0;
        end else if (byte_ok) begin
            if (drop_q) begin
                if (byte_last) drop_d = 1'b0;
            end else if (ready && !take) begin
                if (!closed_q) begin
                    pk_d.last = 1'b1;
                    pk_d.ovr  = 1'b1;
                    closed_d  = 1'b1;
                end
                drop_d     = ~byte_last;
                in_frame_d = 1'b0;
            end else begin
                lane = int'(pk_d.nbytes);
                pk_d.data[lane*BYTE_W +: BYTE_W] = byte_in;
                pk_d.nbytes = pk_d.nbytes + CNT_W'(1);
                if (byte_last) begin
                    closed_d    = 1'b1;
                    pk_d.last   = 1'b1;
                    pk_d.crc    = byte_crc;
                    pk_d.nonoct = byte_non;
                    in_frame_d  = 1'b0;
                end else begin
                    in_frame_d  = 1'b1;
                end
            end
        end
    end

    // Register the packing stage, cleared by reset or soft clear
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            pk_q       <= '0;
            closed_q   <= 1'b0;
            in_frame_q <= 1'b0;
            drop_q     <= 1'b0;
        end else begin
            pk_q       <= pk_d;
            closed_q   <= closed_d;
            in_frame_q <= in_frame_d;
            drop_q     <= drop_d;
        end
    end

    a_r1_pack_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pk_q.nbytes <= CNT_W'(WORD_BYTES));
    a_r2_closed_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        closed_q |-> (pk_q.nbytes != '0) && pk_q.last);
    a_r3_drop_excludes_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !(drop_q && in_frame_q));
endmodule

// File: rtl/hdlc_rxf_store.sv
// Word store: circular buffer of DEPTH tagged words with write, read and
// commit pointers. The commit pointer marks the end of the last whole frame
// (or the read pointer, if reads went past it). A flush returns the write
// pointer to it in one cycle. Reads are registered; an empty read gives zero.
// Assumes DEPTH is a power of two and a non-last word never arrives with flush.
module hdlc_rxf_store
    import hdlc_rxf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LW    = $clog2(DEPTH) + 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      soft_clr,
    input  logic      wr_req,
    input  rxf_word_t wr_word,
    output logic      wr_ready,
    input  logic      flush,
    input  logic      rd_en,
    output rxf_word_t rd_word,
    output logic [LW-1:0] level
);
    localparam int PW = LW - 1;

    rxf_word_t mem [DEPTH];
    logic [LW-1:0] wr_q, rd_q, com_q, com_eff;
    logic wr_en, rd_fire;

    // Occupancy and handshake terms
    always_comb begin
        level    = wr_q - rd_q;
        wr_ready = (level != LW'(DEPTH));
        wr_en    = wr_req & wr_ready;
        rd_fire  = rd_en & (level != '0);
        com_eff  = (rd_fire && (rd_q == com_q)) ? com_q + LW'(1) : com_q;
    end

    // Entry write, no reset needed on storage
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_q[PW-1:0]] <= wr_word;
    end

    // Pointer update, commit tracking and registered read port
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            wr_q    <= '0;
            rd_q    <= '0;
            com_q   <= '0;
            rd_word <= '0;
        end else begin
            if (rd_en) rd_word <= rd_fire ? mem[rd_q[PW-1:0]] : '0;
            if (rd_fire) rd_q <= rd_q + LW'(1);
            if (wr_en) begin
                wr_q  <= wr_q + LW'(1);
                com_q <= wr_word.last ? wr_q + LW'(1) : com_eff;
            end else if (flush) begin
                wr_q  <= com_eff;
                com_q <= com_eff;
            end else begin
                com_q <= com_eff;
            end
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q - rd_q) <= LW'(DEPTH));
    a_r5_commit_inside: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q - com_q) <= (wr_q - rd_q));
    a_r5_flush_write_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && wr_en) |-> wr_word.last);
    a_r8_soft_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_clr) |-> (wr_q == rd_q));
endmodule

// File: rtl/hdlc_rxf_avail.sv
// Threshold flag: compares the stored word count with one or BIG words
// according to the mode select. Assumes BIG does not exceed the store depth.
module hdlc_rxf_avail #(
    parameter int LW  = 4,
    parameter int BIG = 4
) (
    input  logic [LW-1:0] level,
    input  logic          mode_big,
    output logic          avail
);
    // Pick the active threshold
    always_comb begin
        if (mode_big) avail = (level >= LW'(BIG));
        else          avail = (level != '0);
    end
endmodule

// File: rtl/hdlc_rx_fifo.sv
// Top of the HDLC receive buffer: packing stage, tagged word store and
// threshold flag. Derives the frame flush from an in-frame abort or from
// carrier loss while auto handling is on, and blocks bytes during carrier loss.
// Assumes status inputs matter only together with in_valid.
module hdlc_rx_fifo
    import hdlc_rxf_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int THRESH_HI = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_clr,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    input  logic        in_last,
    input  logic        in_crc_err,
    input  logic        in_non_octet,
    input  logic        abort_in,
    input  logic        carrier_lost,
    input  logic        auto_en,
    input  logic        mode_4w,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    output logic [2:0]  rd_nbytes,
    output logic        rd_last,
    output logic        rd_ovr,
    output logic        rd_crc,
    output logic        rd_nonoct,
    output logic        data_avail
);
    localparam int LW = $clog2(DEPTH) + 1;

    logic          carrier_blk, byte_ok, flush, busy;
    logic          pk_valid, st_ready;
    rxf_word_t     pk_word, rd_word;
    logic [LW-1:0] level;

    // Frame discard and byte gating from abort and carrier events
    always_comb begin
        carrier_blk = carrier_lost & auto_en;
        byte_ok     = in_valid & ~carrier_blk;
        flush       = (abort_in | carrier_blk) & busy;
    end

    hdlc_rxf_packer u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_clr   (soft_clr),
        .byte_ok    (byte_ok),
        .byte_in    (in_byte),
        .byte_last  (in_last),
        .byte_crc   (in_crc_err),
        .byte_non   (in_non_octet),
        .flush      (flush),
        .sink_ready (st_ready),
        .out_valid  (pk_valid),
        .out_word   (pk_word),
        .busy       (busy)
    );

    hdlc_rxf_store #(.DEPTH(DEPTH), .LW(LW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .wr_req   (pk_valid),
        .wr_word  (pk_word),
        .wr_ready (st_ready),
        .flush    (flush),
        .rd_en    (rd_en),
        .rd_word  (rd_word),
        .level    (level)
    );

    hdlc_rxf_avail #(.LW(LW), .BIG(THRESH_HI)) u_avail (
        .level    (level),
        .mode_big (mode_4w),
        .avail    (data_avail)
    );

    // Unpack the registered read word onto the ports
    always_comb begin
        rd_data   = rd_word.data;
        rd_nbytes = rd_word.nbytes;
        rd_last   = rd_word.last;
        rd_ovr    = rd_word.ovr;
        rd_crc    = rd_word.crc;
        rd_nonoct = rd_word.nonoct;
    end

    a_r9_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mode_4w && !data_avail) |=> (rd_data == '0) && (rd_nbytes == '0) && !rd_last);
    a_r6_carrier_blocks_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_lost && auto_en && !busy) |=> !busy);
endmodule

// File: tb/hdlc_rx_fifo_test.sv
module hdlc_rx_fifo_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_clr = 1'b0, in_valid = 1'b0, in_last = 1'b0, in_crc_err = 1'b0, in_non_octet = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic abort_in = 1'b0, carrier_lost = 1'b0, auto_en = 1'b0, mode_4w = 1'b0, rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [2:0]  rd_nbytes;
    logic rd_last, rd_ovr, rd_crc, rd_nonoct, data_avail;
    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hdlc_rx_fifo uut (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .in_valid(in_valid), .in_byte(in_byte),
        .in_last(in_last), .in_crc_err(in_crc_err), .in_non_octet(in_non_octet),
        .abort_in(abort_in), .carrier_lost(carrier_lost), .auto_en(auto_en), .mode_4w(mode_4w),
        .rd_en(rd_en), .rd_data(rd_data), .rd_nbytes(rd_nbytes), .rd_last(rd_last),
        .rd_ovr(rd_ovr), .rd_crc(rd_crc), .rd_nonoct(rd_nonoct), .data_avail(data_avail)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic last, input logic crc, input logic non);
        in_valid = 1'b1; in_byte = b; in_last = last; in_crc_err = crc; in_non_octet = non;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_crc_err = 1'b0; in_non_octet = 1'b0;
    endtask

    // Read one word and compare data and {nbytes,last,ovr,crc,nonoct}
    task automatic rd_expect(input string req, input logic [31:0] data, input logic [2:0] n,
                             input logic last, input logic ovr, input logic crc, input logic non);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk({req, " data"}, rd_data, data);
        chk({req, " tags"}, {25'd0, rd_nbytes, rd_last, rd_ovr, rd_crc, rd_nonoct},
            {25'd0, n, last, ovr, crc, non});
    endtask

    task automatic t_reset;
        chk("R8 reset avail", {31'd0, data_avail}, 32'd0);
        chk("R8 reset data", rd_data, 32'd0);
    endtask

    task automatic t_pack;
        for (int i = 1; i <= 6; i++) send(8'(i), i == 6, i == 6, 1'b0);
        send(8'h5A, 1'b1, 1'b0, 1'b1);
        idle(2);
        rd_expect("R1 full word", 32'h04030201, 3'd4, 0, 0, 0, 0);
        rd_expect("R2 partial close crc", 32'h00000605, 3'd2, 1, 0, 1, 0);
        rd_expect("R2 single byte nonoct", 32'h0000005A, 3'd1, 1, 0, 0, 1);
    endtask

    task automatic t_avail;
        for (int i = 0; i < 12; i++) send(8'(8'h10 + i), i == 11, 1'b0, 1'b0);
        idle(2);
        mode_4w = 1'b1; #1;
        chk("R4 three words 4w", {31'd0, data_avail}, 32'd0);
        mode_4w = 1'b0; #1;
        chk("R4 three words 1w", {31'd0, data_avail}, 32'd1);
        for (int i = 0; i < 4; i++) send(8'(8'h40 + i), i == 3, 1'b0, 1'b0);
        idle(2);
        mode_4w = 1'b1; #1;
        chk("R4 four words 4w", {31'd0, data_avail}, 32'd1);
        mode_4w = 1'b0;
        idle(1);
        rd_expect("R1 order w0", 32'h13121110, 3'd4, 0, 0, 0, 0);
        rd_expect("R1 order w1", 32'h17161514, 3'd4, 0, 0, 0, 0);
        rd_expect("R1 order w2", 32'h1B1A1918, 3'd4, 1, 0, 0, 0);
        rd_expect("R1 order w3", 32'h43424140, 3'd4, 1, 0, 0, 0);
    endtask

    task automatic t_abort;
        send(8'hAA, 0, 0, 0); send(8'hBB, 0, 0, 0); send(8'hCC, 1, 0, 0);
        for (int i = 0; i < 6; i++) send(8'(8'h70 + i), 1'b0, 1'b0, 1'b0);
        idle(2);
        abort_in = 1'b1; @(negedge clk); abort_in = 1'b0;
        idle(2);
        rd_expect("R5 earlier frame kept", 32'h00CCBBAA, 3'd3, 1, 0, 0, 0);
        chk("R5 aborted frame gone", {31'd0, data_avail}, 32'd0);
        send(8'hD1, 0, 0, 0); send(8'hD2, 1, 0, 0);
        idle(2);
        rd_expect("R5 next frame intact", 32'h0000D2D1, 3'd2, 1, 0, 0, 0);
    endtask

    task automatic t_abort_idle;
        for (int i = 0; i < 4; i++) send(8'(8'hE0 + i), i == 3, 1'b0, 1'b0);
        idle(2);
        abort_in = 1'b1; @(negedge clk); abort_in = 1'b0;
        idle(2);
        chk("R7 avail after idle abort", {31'd0, data_avail}, 32'd1);
        rd_expect("R7 word unchanged", 32'hE3E2E1E0, 3'd4, 1, 0, 0, 0);
    endtask

    task automatic t_carrier;
        auto_en = 1'b1;
        send(8'h21, 0, 0, 0); send(8'h22, 1, 0, 0);
        for (int i = 0; i < 5; i++) send(8'(8'h30 + i), 1'b0, 1'b0, 1'b0);
        idle(1);
        carrier_lost = 1'b1;
        send(8'h99, 0, 0, 0); send(8'h98, 1, 0, 0);
        idle(1);
        carrier_lost = 1'b0;
        idle(2);
        rd_expect("R6 earlier frame kept", 32'h00002221, 3'd2, 1, 0, 0, 0);
        chk("R6 frame dropped and bytes ignored", {31'd0, data_avail}, 32'd0);
        auto_en = 1'b0;
        carrier_lost = 1'b1;
        for (int i = 0; i < 4; i++) send(8'(8'h50 + i), i == 3, 1'b0, 1'b0);
        idle(2);
        carrier_lost = 1'b0;
        rd_expect("R6 no effect without auto", 32'h53525150, 3'd4, 1, 0, 0, 0);
    endtask

    task automatic t_overrun;
        for (int i = 1; i <= 40; i++) send(8'(i), i == 40, 1'b0, 1'b0);
        idle(2);
        for (int w = 0; w < 8; w++)
            rd_expect("R3 stored word", {8'(4*w+4), 8'(4*w+3), 8'(4*w+2), 8'(4*w+1)}, 3'd4, 0, 0, 0, 0);
        idle(1);
        rd_expect("R3 overrun tag", 32'h24232221, 3'd4, 1, 1, 0, 0);
        idle(1);
        chk("R3 tail dropped", {31'd0, data_avail}, 32'd0);
        send(8'hA1, 0, 0, 0); send(8'hB2, 1, 0, 0);
        idle(2);
        rd_expect("R3 next frame after drop", 32'h0000B2A1, 3'd2, 1, 0, 0, 0);
    endtask

    task automatic t_soft_clear;
        for (int i = 0; i < 8; i++) send(8'(8'h60 + i), i == 7, 1'b0, 1'b0);
        send(8'h6F, 0, 0, 0);
        idle(2);
        soft_clr = 1'b1; @(negedge clk); soft_clr = 1'b0;
        chk("R8 soft clear avail", {31'd0, data_avail}, 32'd0);
        rd_expect("R8 soft clear read", 32'd0, 3'd0, 0, 0, 0, 0);
        send(8'h77, 1, 0, 0);
        idle(2);
        rd_expect("R8 fresh after clear", 32'h00000077, 3'd1, 1, 0, 0, 0);
    endtask

    task automatic t_empty_read;
        rd_expect("R9 empty read", 32'd0, 3'd0, 0, 0, 0, 0);
        rd_expect("R9 empty read again", 32'd0, 3'd0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) send(8'(8'hC0 + i), i == 3, 1'b0, 1'b0);
        idle(2);
        rd_expect("R9 pointer unmoved", 32'hC3C2C1C0, 3'd4, 1, 0, 0, 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_pack;
        t_avail;
        t_abort;
        t_abort_idle;
        t_carrier;
        t_overrun;
        t_soft_clear;
        t_empty_read;
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule